// File: doc/BRIEF.md
# Completion Error Header Logger

This block sits on the application side of a PCI Express endpoint and reports a completion error to the core together with the 128-bit header of the packet that caused it. The application presents one error request. The request carries the error bits to raise, a flag that asks for header logging, the header itself and the number of the function the error belongs to.

When logging is requested, the block first loads the header into four error-descriptor registers of the core. It does this with four write transactions on a local management port, and it waits for an acknowledge after each write. Only then does it raise the error vector with the header-log bit set. When logging is not requested, it skips the writes and raises the error bits at once. In both cases the error pulse lasts exactly one clock. A busy output keeps new requests out until that pulse has been issued.

Top module: `hel_err_logger`

## Requirements
- R1: After reset, `busy`, `mgmt_wr`, `err_vec` and `err_func` are all low.
- R2: A request is taken on a rising edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the error pulse cycle ends. A `req_valid` seen while `busy` is high is ignored and changes neither the writes nor the pulse.
- R3: A logged request issues exactly four writes, at management addresses 0x81C, 0x820, 0x824 and 0x828 in that order. The first write appears in the cycle after acceptance.
- R4: The write to 0x81C carries header bits [127:96], 0x820 carries [95:64], 0x824 carries [63:32] and 0x828 carries [31:0].
- R5: `mgmt_wr` is a one-cycle pulse. The block waits as long as needed for `mgmt_ack`, and it issues the next write in the cycle after the acknowledge is sampled. An acknowledge that arrives in the cycle of the write pulse, or when no write is outstanding, is ignored.
- R6: For a logged request, the error pulse appears in the cycle after the fourth acknowledge is sampled, and never before all four writes.
- R7: For a logged request, bit 6 of `err_vec` is high in the same single cycle as the requested error bits [5:0]. This holds whatever combination of bits 2 to 5 (bit 5 being the unsupported-request error) is requested.
- R8: For a request without logging, no write is issued. `err_vec` carries the requested bits with bit 6 low, in the cycle after acceptance.
- R9: `err_vec` is non-zero for exactly one cycle per request. During that cycle `err_func` carries the request's 3-bit function number, and it is zero in every other cycle.
- R10: `busy` falls in the cycle after the error pulse, and a request held high is taken again on that cycle's closing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Error request strobe |
| req_err_bits | input | 6 | Error bits [5:0] to raise |
| req_log | input | 1 | Request header logging |
| req_hdr | input | 128 | Header of the offending packet |
| req_func | input | 3 | Function number of the error |
| busy | output | 1 | Request in progress; new requests ignored |
| mgmt_wr | output | 1 | Management write pulse |
| mgmt_addr | output | 12 | Management write address |
| mgmt_wdata | output | 32 | Management write data |
| mgmt_ack | input | 1 | Management write acknowledge |
| err_vec | output | 7 | Completion error vector, bit 6 = header logged |
| err_func | output | 3 | Function number of the reported error |

## Verification
The assertions check on every cycle the following points. The write strobe never lasts two cycles. Each write address matches the count of writes since acceptance. The log bit is raised only after exactly four writes, and an unlogged pulse only after none. The error pulse is a single cycle inside a busy window. The correct header slice in each write, how long the block waits for slow or stray acknowledges, and the rejection of requests while busy depend on the data and timing of each request. These are shown by the bench's scenarios against its cycle model.

// File: rtl/hel_pkg.sv
package hel_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FIRE  = 2'd3
   } hel_state_e;
endpackage

// File: rtl/hel_req_capture.sv
module hel_req_capture #(
   parameter int HDR_W  = 128,
   parameter int BITS_W = 6,
   parameter int FUNC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BITS_W-1:0] bits_in,
   input  logic              log_in,
   input  logic [HDR_W-1:0]  hdr_in,
   input  logic [FUNC_W-1:0] func_in,
   output logic [BITS_W-1:0] bits_q,
   output logic              log_q,
   output logic [HDR_W-1:0]  hdr_q,
   output logic [FUNC_W-1:0] func_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
         log_q  <= 1'b0;
         hdr_q  <= '0;
         func_q <= '0;
      end else if (load) begin
         bits_q <= bits_in;
         log_q  <= log_in;
         hdr_q  <= hdr_in;
         func_q <= func_in;
      end
   end
endmodule

// File: rtl/hel_word_sel.sv
module hel_word_sel #(
   parameter int          HDR_W     = 128,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 12,
   parameter logic [11:0] BASE_ADDR = 12'h81C,
   parameter int          ADDR_STEP = 4,
   parameter bit          MSW_FIRST = 1'b1,
   localparam int         NWORDS    = HDR_W / DATA_W,
   localparam int         IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [HDR_W-1:0]  hdr,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] words [NWORDS];
   logic [ADDR_W-1:0] addrs [NWORDS];

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      assign addrs[k] = ADDR_W'(BASE_ADDR) + ADDR_W'(k * ADDR_STEP);
      if (MSW_FIRST) begin : g_msw
         assign words[k] = hdr[HDR_W-1-k*DATA_W -: DATA_W];
      end else begin : g_lsw
         assign words[k] = hdr[k*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      addr = '0;
      data = '0;
      for (int k = 0; k < NWORDS; k++) begin
         if (idx == IDX_W'(k)) begin
            addr = addrs[k];
            data = words[k];
         end
      end
   end
endmodule

// File: rtl/hel_ctrl_fsm.sv
module hel_ctrl_fsm
   import hel_pkg::*;
#(
   parameter int  NWORDS = 4,
   localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_log,
   input  logic             ack,
   output logic             load,
   output logic             wr_pulse,
   output logic             fire,
   output logic             busy,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

   hel_state_e state;

   assign load     = (state == ST_IDLE) && req_valid;
   assign wr_pulse = (state == ST_ISSUE);
   assign fire     = (state == ST_FIRE);
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  idx   <= '0;
                  state <= req_log ? ST_ISSUE : ST_FIRE;
               end
            end
            ST_ISSUE: state <= ST_WAIT;
            ST_WAIT: begin
               if (ack) begin
                  if (idx == LAST_IDX) begin
                     state <= ST_FIRE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_ISSUE;
                  end
               end
            end
            ST_FIRE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hel_err_logger.sv
module hel_err_logger #(
   parameter int          HDR_W     = 128,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 12,
   parameter int          ERR_W     = 7,
   parameter int          FUNC_W    = 3,
   parameter logic [11:0] BASE_ADDR = 12'h81C,
   parameter int          ADDR_STEP = 4,
   parameter bit          MSW_FIRST = 1'b1,
   localparam int         BITS_W    = ERR_W - 1,
   localparam int         NWORDS    = HDR_W / DATA_W,
   localparam int         IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BITS_W-1:0] req_err_bits,
   input  logic              req_log,
   input  logic [HDR_W-1:0]  req_hdr,
   input  logic [FUNC_W-1:0] req_func,
   output logic              busy,
   output logic              mgmt_wr,
   output logic [ADDR_W-1:0] mgmt_addr,
   output logic [DATA_W-1:0] mgmt_wdata,
   input  logic              mgmt_ack,
   output logic [ERR_W-1:0]  err_vec,
   output logic [FUNC_W-1:0] err_func
);
   if (HDR_W != NWORDS * DATA_W) begin : g_bad_split
      $error("header width must be a whole number of data words");
   end
   if (ERR_W < 2) begin : g_bad_err
      $error("error vector needs at least one error bit and the log bit");
   end

   logic              load, fire, busy_i, wr_i;
   logic [IDX_W-1:0]  idx;
   logic [BITS_W-1:0] bits_q;
   logic              log_q;
   logic [HDR_W-1:0]  hdr_q;
   logic [FUNC_W-1:0] func_q;

   hel_ctrl_fsm #(.NWORDS(NWORDS)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_log  (req_log),
      .ack      (mgmt_ack),
      .load     (load),
      .wr_pulse (wr_i),
      .fire     (fire),
      .busy     (busy_i),
      .idx      (idx)
   );

   hel_req_capture #(.HDR_W(HDR_W), .BITS_W(BITS_W), .FUNC_W(FUNC_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .bits_in(req_err_bits),
      .log_in (req_log),
      .hdr_in (req_hdr),
      .func_in(req_func),
      .bits_q (bits_q),
      .log_q  (log_q),
      .hdr_q  (hdr_q),
      .func_q (func_q)
   );

   hel_word_sel #(
      .HDR_W(HDR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .BASE_ADDR(BASE_ADDR), .ADDR_STEP(ADDR_STEP), .MSW_FIRST(MSW_FIRST)
   ) u_sel (
      .idx (idx),
      .hdr (hdr_q),
      .addr(mgmt_addr),
      .data(mgmt_wdata)
   );

   assign busy     = busy_i;
   assign mgmt_wr  = wr_i;
   assign err_vec  = fire ? {log_q, bits_q} : '0;
   assign err_func = fire ? func_q : '0;
endmodule

// File: rtl/hel_checker.sv
module hel_checker #(
   parameter int          ERR_W     = 7,
   parameter int          ADDR_W    = 12,
   parameter int          NWORDS    = 4,
   parameter logic [11:0] BASE_ADDR = 12'h81C,
   parameter int          ADDR_STEP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              mgmt_wr,
   input logic [ADDR_W-1:0] mgmt_addr,
   input logic [ERR_W-1:0]  err_vec
);
   logic [7:0] wr_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 wr_cnt <= '0;
      else if (req_valid && !busy) wr_cnt <= '0;
      else if (mgmt_wr && wr_cnt != 8'hFF) wr_cnt <= wr_cnt + 8'd1;
   end

   // R5: write strobe never lasts two cycles
   a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_wr |=> !mgmt_wr);

   // R3: address follows the write count since acceptance
   a_r3_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_wr |-> (mgmt_addr == ADDR_W'(BASE_ADDR) + ADDR_W'(int'(wr_cnt) * ADDR_STEP)));

   // R6: log bit only after all writes
   a_r6_log_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
      err_vec[ERR_W-1] |-> (wr_cnt == 8'(NWORDS)));

   // R8: unlogged pulse issues no writes
   a_r8_no_writes: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_vec != '0) && !err_vec[ERR_W-1]) |-> (wr_cnt == 8'd0));

   // R9: error pulse lasts one cycle
   a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vec != '0) |=> (err_vec == '0));

   // R2: accepted request makes the block busy; pulse sits inside busy
   a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   a_r2_pulse_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vec != '0) |-> busy);
endmodule

bind hel_err_logger hel_checker #(
   .ERR_W(ERR_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS),
   .BASE_ADDR(BASE_ADDR), .ADDR_STEP(ADDR_STEP)
) u_hel_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .busy     (busy),
   .mgmt_wr  (mgmt_wr),
   .mgmt_addr(mgmt_addr),
   .err_vec  (err_vec)
);

// File: tb/hel_err_logger_bench.sv
`timescale 1ns/1ps
module hel_err_logger_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [5:0]   req_err_bits = '0;
   logic         req_log = 1'b0;
   logic [127:0] req_hdr = '0;
   logic [2:0]   req_func = '0;
   logic         busy, mgmt_wr, mgmt_ack;
   logic [11:0]  mgmt_addr;
   logic [31:0]  mgmt_wdata;
   logic [6:0]   err_vec;
   logic [2:0]   err_func;

   logic ack_auto = 1'b0;
   logic stray    = 1'b0;
   int   ack_delay = 1;
   int   ack_cnt   = 0;
   assign mgmt_ack = ack_auto | stray;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   hel_err_logger u_hel_err_logger (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_err_bits(req_err_bits),
      .req_log(req_log), .req_hdr(req_hdr), .req_func(req_func), .busy(busy),
      .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
      .mgmt_ack(mgmt_ack), .err_vec(err_vec), .err_func(err_func)
   );

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // Behavioural model: what should be visible in the coming cycle
   int           m_phase = 0;  // 0 idle, 1 write shown, 2 awaiting ack, 3 pulse
   int           m_word  = 0;
   logic [127:0] m_hdr;
   logic [5:0]   m_bits;
   logic         m_log;
   logic [2:0]   m_func;
   int           wr_seen = 0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_phase = 0; m_word = 0;
      end else begin
         case (m_phase)
            0: if (req_valid) begin
                  m_hdr = req_hdr; m_bits = req_err_bits; m_log = req_log;
                  m_func = req_func; m_word = 0;
                  m_phase = req_log ? 1 : 3;
               end
            1: m_phase = 2;
            2: if (mgmt_ack) begin
                  if (m_word == 3) m_phase = 3;
                  else begin m_word++; m_phase = 1; end
               end
            default: m_phase = 0;
         endcase
      end
   end

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 busy", 128'(busy), 128'(m_phase != 0));
         check("R5 mgmt_wr", 128'(mgmt_wr), 128'(m_phase == 1));
         if (m_phase == 1) begin
            check("R3 mgmt_addr", 128'(mgmt_addr), 128'(12'h81C + 12'(4 * m_word)));
            check("R4 mgmt_wdata", 128'(mgmt_wdata), 128'(m_hdr[127 - 32*m_word -: 32]));
         end
         if (m_phase == 3) begin
            check(m_log ? "R7 err_vec" : "R8 err_vec", 128'(err_vec), 128'({m_log, m_bits}));
            check("R9 err_func", 128'(err_func), 128'(m_func));
         end else begin
            check("R9 err_vec idle", 128'(err_vec), 128'(0));
            check("R9 err_func idle", 128'(err_func), 128'(0));
         end
         if (mgmt_wr) wr_seen++;
         if (err_vec[6]) begin
            check("R6 writes before log", 128'(wr_seen), 128'(4));
         end
         if (err_vec != 0) wr_seen = 0;
      end
   end

   // Acknowledge responder
   always @(negedge clk) begin
      ack_auto = 1'b0;
      if (ack_cnt > 0) begin
         ack_cnt--;
         if (ack_cnt == 0) ack_auto = 1'b1;
      end else if (mgmt_wr) begin
         ack_cnt = ack_delay;
      end
   end

   task automatic send(input logic [5:0] bits, input logic lg,
                       input logic [127:0] hdr, input logic [2:0] fn);
      @(negedge clk);
      req_valid = 1'b1; req_err_bits = bits; req_log = lg; req_hdr = hdr; req_func = fn;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (m_phase != 0) @(negedge clk);
   endtask

   // Watchdog
   always @(posedge clk) begin
      if (cycles > 20000 && !done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy", 128'(busy), 0);
      check("R1 mgmt_wr", 128'(mgmt_wr), 0);
      check("R1 err_vec", 128'(err_vec), 0);
      check("R1 err_func", 128'(err_func), 0);
      rst_n = 1'b1;

      // R3 R4 R7: unsupported-request error, logged, fast ack
      ack_delay = 1;
      send(6'b100000, 1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 3'd3);
      wait_idle();

      // R5 R6: slow ack, bits 2 and 4
      ack_delay = 4;
      send(6'b010100, 1'b1, 128'hDEAD_BEEF_CAFE_F00D_1111_2222_3333_4444, 3'd5);
      wait_idle();

      // R8: no logging
      send(6'b001000, 1'b0, 128'hFFFF_0000_FFFF_0000_AAAA_5555_AAAA_5555, 3'd1);
      wait_idle();

      // R2: request while busy is ignored
      ack_delay = 3;
      send(6'b000100, 1'b1, 128'h1, 3'd2);
      req_valid = 1'b1; req_err_bits = 6'b111111; req_log = 1'b0; req_func = 3'd7;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();

      // R5: stray acknowledges while idle and during a write pulse
      stray = 1'b1; @(negedge clk); stray = 1'b0;
      check("R5 stray ack idle", 128'(busy), 0);
      ack_delay = 2;
      @(negedge clk);
      req_valid = 1'b1; req_err_bits = 6'b100100; req_log = 1'b1;
      req_hdr = 128'hA5A5_5A5A_0F0F_F0F0_1234_5678_9ABC_DEF0; req_func = 3'd6;
      @(negedge clk);
      req_valid = 1'b0; stray = 1'b1;   // write pulse cycle
      @(negedge clk);
      stray = 1'b0;
      wait_idle();

      // R10: held request is taken again as soon as busy falls
      ack_delay = 1;
      @(negedge clk);
      req_valid = 1'b1; req_err_bits = 6'b000011; req_log = 1'b0; req_func = 3'd4;
      @(negedge clk);
      @(negedge clk);
      check("R10 busy low after pulse", 128'(busy), 0);
      @(negedge clk);
      check("R10 re-accepted pulse", 128'(err_vec), 128'(7'b0000011));
      req_valid = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule